// File: doc/BRIEF.md
# Flag Threshold Register Sequencer

This block holds the two threshold values that set how close to empty and how close to full a dual-clock FIFO's almost-empty and almost-full flags switch on. Software programs and reads these thresholds through the FIFO's own data path, not through a separate register bus. While the `prog` select is high, a write-enable edge on the write clock stores the low bits of the write word into a threshold register. A read-enable edge on the read clock returns a threshold on a readback port, together with a one-cycle valid strobe.

The block has no register addresses. One shared sequence position chooses the register that is used next. The empty threshold comes first and the full threshold second, and the two alternate after that. The position survives the end of a programming session. It moves on with every programming access in either clock domain, and the two domains are assumed never to access it in the same cycle.

When `prog` is low, the enables pass through as ordinary FIFO write and read qualifiers. Both thresholds are always driven to the flag logic. The FIFO storage and its pointers are outside this block.

Top module: `ofs_seq_top`

## Requirements
- R1: After reset, `empty_ofs` equals `EMPTY_DEF` and `full_ofs` equals `FULL_DEF`, `rb_valid` is 0, and the next programming access targets the empty threshold, even if the previous session stopped on the full one.
- R2: At a rising `wr_clk` edge with `prog`=1 and `wr_en`=1, `wr_data[OFS_W-1:0]` is stored into the register at the current sequence position: empty, then full, then empty again. The upper data bits are ignored.
- R3: At a rising `wr_clk` edge with `wr_en`=0, neither threshold changes and the sequence does not advance, whatever the level of `prog`.
- R4: `fifo_wr` is high exactly while `wr_en`=1 and `prog`=0, and `fifo_rd` is high exactly while `rd_en`=1 and `prog`=0. Such accesses leave both thresholds unchanged.
- R5: The sequence position is kept when `prog` falls and rises again. A new session continues with the register after the last one accessed.
- R6: At a rising `rd_clk` edge with `prog`=1 and `rd_en`=1, the register at the current position is driven on `rb_data`, zero-extended to `DATA_W` bits, and `rb_valid` is 1 for the next cycle. The position then advances.
- R7: Writes and readbacks share one position: an access in either domain moves the position seen by the other domain.
- R8: After a `rd_clk` edge without a readback access, `rb_valid` is 0 and `rb_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low, shared by both domains |
| prog | input | 1 | Routes enabled accesses to the threshold registers |
| wr_en | input | 1 | Write enable, active high |
| rd_en | input | 1 | Read enable, active high |
| wr_data | input | DATA_W | Write word; bits OFS_W-1:0 load a threshold |
| empty_ofs | output | OFS_W | Almost-empty threshold to the flag logic |
| full_ofs | output | OFS_W | Almost-full threshold to the flag logic |
| fifo_wr | output | 1 | Qualified ordinary FIFO write |
| fifo_rd | output | 1 | Qualified ordinary FIFO read |
| rb_data | output | DATA_W | Zero-extended threshold readback word |
| rb_valid | output | 1 | One-cycle strobe marking new readback data |

## Verification
The bench builds the block with `DEPTH`=512, so both reset thresholds are 0x040. This value cannot be mistaken for any programmed pattern, so a register that is written when it should not be shows up at once. It keeps `DATA_W`=18 and `OFS_W`=12. The six unused high bits are set to ones in one write, which shows that they are dropped, and they must read back as zeros. Programming writes and readbacks are interleaved across sessions, so the shared position is tested across both clocks. A reset in the middle of a sequence shows that the position returns to the empty register.

// File: rtl/ofs_seq_pkg.sv
package ofs_seq_pkg;

    // Which threshold register the shared sequence position points at.
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_e;

    // The position is split into one toggle per clock domain; their parity
    // names the register that the next access uses.
    function automatic slot_e slot_of(input logic own_tog, input logic peer_tog);
        return slot_e'(own_tog ^ peer_tog);
    endfunction

endpackage

// File: rtl/ofs_wr_side.sv
module ofs_wr_side
    import ofs_seq_pkg::*;
#(
    parameter int OFS_W     = 12,
    parameter int EMPTY_DEF = 128,
    parameter int FULL_DEF  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_val,
    input  logic             peer_tog,
    output logic             tog,
    output logic [OFS_W-1:0] empty_ofs,
    output logic [OFS_W-1:0] full_ofs,
    output logic             fifo_wr
);

    localparam logic [OFS_W-1:0] EMPTY_INIT = OFS_W'(EMPTY_DEF);
    localparam logic [OFS_W-1:0] FULL_INIT  = OFS_W'(FULL_DEF);

    typedef struct packed {
        logic [1:0][OFS_W-1:0] ofs;
        logic                  tog;
    } wst_t;

    wst_t  st_d, st_q;
    slot_e slot;
    logic  load;

    always_comb begin
        st_d    = st_q;
        slot    = slot_of(st_q.tog, peer_tog);
        load    = wr_en & prog;
        fifo_wr = wr_en & ~prog;
        if (load) begin
            st_d.ofs[slot] = wr_val;
            st_d.tog       = ~st_q.tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ofs[SLOT_EMPTY] <= EMPTY_INIT;
            st_q.ofs[SLOT_FULL]  <= FULL_INIT;
            st_q.tog             <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tog       = st_q.tog;
    assign empty_ofs = st_q.ofs[SLOT_EMPTY];
    assign full_ofs  = st_q.ofs[SLOT_FULL];

    assert_load_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && prog && (tog ^ peer_tog) == 1'b0)
        |=> (empty_ofs == $past(wr_val)) && $stable(full_ofs));

    assert_load_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && prog && (tog ^ peer_tog) == 1'b1)
        |=> (full_ofs == $past(wr_val)) && $stable(empty_ofs));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(empty_ofs) && $stable(full_ofs) && $stable(tog));

    assert_plain_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |=> $stable(empty_ofs) && $stable(full_ofs));

    assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && prog) |=> (tog != $past(tog)));

endmodule

// File: rtl/ofs_rd_side.sv
module ofs_rd_side
    import ofs_seq_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int OFS_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  logic              rd_en,
    input  logic              peer_tog,
    input  logic [OFS_W-1:0]  empty_ofs,
    input  logic [OFS_W-1:0]  full_ofs,
    output logic              tog,
    output logic [DATA_W-1:0] rb_data,
    output logic              rb_valid,
    output logic              fifo_rd
);

    typedef struct packed {
        logic [DATA_W-1:0] rb;
        logic              vld;
        logic              tog;
    } rst_t;

    rst_t              st_d, st_q;
    slot_e             slot;
    logic              fetch;
    logic [OFS_W-1:0]  picked;
    logic [DATA_W-1:0] widened;

    always_comb begin
        slot   = slot_of(st_q.tog, peer_tog);
        picked = (slot == SLOT_FULL) ? full_ofs : empty_ofs;
    end

    // Fit the threshold to the output word: zero-extend or truncate.
    generate
        if (DATA_W > OFS_W) begin : g_zext
            assign widened = {{(DATA_W-OFS_W){1'b0}}, picked};
        end else begin : g_trunc
            assign widened = picked[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        fetch    = rd_en & prog;
        fifo_rd  = rd_en & ~prog;
        st_d.vld = fetch;
        if (fetch) begin
            st_d.rb  = widened;
            st_d.tog = ~st_q.tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tog      = st_q.tog;
    assign rb_data  = st_q.rb;
    assign rb_valid = st_q.vld;

    assert_rb_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && prog && (tog ^ peer_tog) == 1'b0)
        |=> rb_valid && (rb_data[OFS_W-1:0] == $past(empty_ofs)));

    assert_rb_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && prog && (tog ^ peer_tog) == 1'b1)
        |=> rb_valid && (rb_data[OFS_W-1:0] == $past(full_ofs)));

    assert_rb_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && prog) |=> !rb_valid && $stable(rb_data) && $stable(tog));

    generate
        if (DATA_W > OFS_W) begin : g_zchk
            assert_rb_zero_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
                rb_valid |-> (rb_data[DATA_W-1:OFS_W] == '0));
        end
    endgenerate

endmodule

// File: rtl/ofs_seq_top.sv
module ofs_seq_top #(
    parameter int DEPTH     = 1024,
    parameter int DATA_W    = 18,
    parameter int OFS_W     = 12,
    parameter int EMPTY_DEF = DEPTH / 8,
    parameter int FULL_DEF  = DEPTH / 8
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              prog,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs,
    output logic              fifo_wr,
    output logic              fifo_rd,
    output logic [DATA_W-1:0] rb_data,
    output logic              rb_valid
);

    logic wr_tog, rd_tog;

    // Only the low OFS_W bits program a threshold.
    generate
        if (DATA_W > OFS_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^wr_data[DATA_W-1:OFS_W];
        end
    endgenerate

    ofs_wr_side #(
        .OFS_W    (OFS_W),
        .EMPTY_DEF(EMPTY_DEF),
        .FULL_DEF (FULL_DEF)
    ) u_wr (
        .clk      (wr_clk),
        .rst_n    (rst_n),
        .prog     (prog),
        .wr_en    (wr_en),
        .wr_val   (wr_data[OFS_W-1:0]),
        .peer_tog (rd_tog),
        .tog      (wr_tog),
        .empty_ofs(empty_ofs),
        .full_ofs (full_ofs),
        .fifo_wr  (fifo_wr)
    );

    // Shared position (R7): each side flips its own toggle, and both sides read the parity.
    ofs_rd_side #(
        .DATA_W(DATA_W),
        .OFS_W (OFS_W)
    ) u_rd (
        .clk      (rd_clk),
        .rst_n    (rst_n),
        .prog     (prog),
        .rd_en    (rd_en),
        .peer_tog (wr_tog),
        .empty_ofs(empty_ofs),
        .full_ofs (full_ofs),
        .tog      (rd_tog),
        .rb_data  (rb_data),
        .rb_valid (rb_valid),
        .fifo_rd  (fifo_rd)
    );

    assert_reset_pos_R1: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $rose(rst_n) |-> (wr_tog == rd_tog));

endmodule

// File: tb/tb_ofs_seq_top.sv
module tb_ofs_seq_top;

    localparam int DATA_W = 18;
    localparam int OFS_W  = 12;
    localparam logic [OFS_W-1:0] DEF = 12'h040;

    logic              wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic              prog = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [OFS_W-1:0]  empty_ofs, full_ofs;
    logic              fifo_wr, fifo_rd, rb_valid;
    logic [DATA_W-1:0] rb_data;

    int compared = 0, mismatched = 0;
    bit finished = 1'b0;

    always #10 wr_clk = ~wr_clk;
    initial begin #5; forever #10 rd_clk = ~rd_clk; end

    ofs_seq_top #(.DEPTH(512), .DATA_W(DATA_W), .OFS_W(OFS_W)) dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .prog(prog),
        .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs), .fifo_wr(fifo_wr),
        .fifo_rd(fifo_rd), .rb_data(rb_data), .rb_valid(rb_valid));

    typedef struct packed {
        logic              rd;
        logic              pg;
        logic              en;
        logic [DATA_W-1:0] din;
        logic [OFS_W-1:0]  e;
        logic [OFS_W-1:0]  f;
        logic              v;
        logic [DATA_W-1:0] rb;
        logic              strobe;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 1'b1, 18'h3F011, 12'h011, 12'h040, 1'b0, 18'h0,     1'b0},
        '{1'b0, 1'b1, 1'b1, 18'h00222, 12'h011, 12'h222, 1'b0, 18'h0,     1'b0},
        '{1'b0, 1'b1, 1'b1, 18'h00333, 12'h333, 12'h222, 1'b0, 18'h0,     1'b0},
        '{1'b0, 1'b0, 1'b1, 18'h00444, 12'h333, 12'h222, 1'b0, 18'h0,     1'b1},
        '{1'b0, 1'b1, 1'b0, 18'h00555, 12'h333, 12'h222, 1'b0, 18'h0,     1'b0},
        '{1'b0, 1'b1, 1'b1, 18'h00666, 12'h333, 12'h666, 1'b0, 18'h0,     1'b0},
        '{1'b1, 1'b1, 1'b1, 18'h0,     12'h333, 12'h666, 1'b1, 18'h00333, 1'b0},
        '{1'b1, 1'b1, 1'b1, 18'h0,     12'h333, 12'h666, 1'b1, 18'h00666, 1'b0},
        '{1'b1, 1'b0, 1'b1, 18'h0,     12'h333, 12'h666, 1'b0, 18'h00666, 1'b1},
        '{1'b0, 1'b1, 1'b1, 18'h00ABC, 12'hABC, 12'h666, 1'b0, 18'h0,     1'b0},
        '{1'b1, 1'b1, 1'b1, 18'h0,     12'hABC, 12'h666, 1'b1, 18'h00666, 1'b0},
        '{1'b1, 1'b1, 1'b1, 18'h0,     12'hABC, 12'h666, 1'b1, 18'h00ABC, 1'b0},
        '{1'b0, 1'b1, 1'b1, 18'h00FFF, 12'hABC, 12'hFFF, 1'b0, 18'h0,     1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply one access on the chosen clock, then sample 2 ns after its rising edge.
    task automatic step(input logic rd, input logic pg, input logic en, input logic [DATA_W-1:0] d);
        if (rd) @(negedge rd_clk); else @(negedge wr_clk);
        prog = pg; wr_data = d;
        wr_en = rd ? 1'b0 : en;
        rd_en = rd ? en : 1'b0;
        if (rd) @(posedge rd_clk); else @(posedge wr_clk);
        #2;
        wr_en = 1'b0; rd_en = 1'b0; prog = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        #45;
        // R1: reset state
        chk("R1 empty_ofs reset", 32'(empty_ofs), 32'(DEF));
        chk("R1 full_ofs reset", 32'(full_ofs), 32'(DEF));
        chk("R1 rb_valid reset", 32'(rb_valid), 32'd0);
        @(negedge wr_clk); rst_n = 1'b1;

        // Table walk covering R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rd) @(negedge rd_clk); else @(negedge wr_clk);
            prog = VEC[i].pg; wr_data = VEC[i].din;
            wr_en = VEC[i].rd ? 1'b0 : VEC[i].en;
            rd_en = VEC[i].rd ? VEC[i].en : 1'b0;
            #1;
            if (VEC[i].rd) chk($sformatf("R4 fifo_rd vec %0d", i), 32'(fifo_rd), 32'(VEC[i].strobe));
            else           chk($sformatf("R4 fifo_wr vec %0d", i), 32'(fifo_wr), 32'(VEC[i].strobe));
            if (VEC[i].rd) @(posedge rd_clk); else @(posedge wr_clk);
            #2;
            wr_en = 1'b0; rd_en = 1'b0; prog = 1'b0;
            chk($sformatf("R2/R3/R5 empty_ofs vec %0d", i), 32'(empty_ofs), 32'(VEC[i].e));
            chk($sformatf("R2/R3/R5 full_ofs vec %0d", i), 32'(full_ofs), 32'(VEC[i].f));
            if (VEC[i].rd) begin
                chk($sformatf("R6/R8 rb_valid vec %0d", i), 32'(rb_valid), 32'(VEC[i].v));
                chk($sformatf("R6/R7 rb_data vec %0d", i), 32'(rb_data), 32'(VEC[i].rb));
            end
        end

        // R8: the strobe lasts one cycle after a readback
        step(1'b1, 1'b1, 1'b1, '0);
        chk("R6 rb_data next empty", 32'(rb_data), 32'h00ABC);
        @(posedge rd_clk); #2;
        chk("R8 rb_valid drops", 32'(rb_valid), 32'd0);
        chk("R8 rb_data holds", 32'(rb_data), 32'h00ABC);

        // R1: reset in mid-sequence goes back to the empty slot and the defaults
        step(1'b0, 1'b1, 1'b1, 18'h00123);
        chk("R7 write after read goes to full", 32'(full_ofs), 32'h123);
        step(1'b0, 1'b1, 1'b1, 18'h00777);
        chk("R2 wraps to empty", 32'(empty_ofs), 32'h777);
        @(negedge wr_clk); rst_n = 1'b0; #3;
        chk("R1 async empty default", 32'(empty_ofs), 32'(DEF));
        chk("R1 async full default", 32'(full_ofs), 32'(DEF));
        @(negedge wr_clk); rst_n = 1'b1;
        step(1'b0, 1'b1, 1'b1, 18'h00456);
        chk("R1 first write targets empty", 32'(empty_ofs), 32'h456);
        chk("R1 full untouched", 32'(full_ofs), 32'(DEF));
        step(1'b1, 1'b1, 1'b1, '0);
        chk("R6 readback after reset", 32'(rb_data), 32'(DEF));
        chk("R6 strobe after reset", 32'(rb_valid), 32'd1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule